// File: doc/BRIEF.md
# Programmable Fault Input Filter

This block cleans up one asynchronous fault line before a timer's protection logic acts on it. A 4-bit mode value selects two things. The first is how often the line is sampled: either on every kernel clock cycle, or once every 2, 4, 8, 16 or 32 dead-time clock periods. The second is how many samples in a row must show a new level before the filtered output takes that level. The required count is 2, 4, 5, 6 or 8. Mode zero turns filtering off, and the output then follows the raw line through logic only, with no register in the path.

In every filtered mode the raw line first passes through a two-flop synchronizer. An event counter then compares each sample with the current filtered level. A sample that differs from the filtered level moves the counter up by one. A sample that equals the filtered level clears the counter. When the count reaches the mode's threshold, the output flips and the counter restarts. The dead-time clock is given to the block as a one-cycle enable, `dts_tick_i`. A prescaler divides that enable down to the selected sampling rate.

Top module: `fault_input_filter`

## Requirements
- R1: While reset is asserted and right after it is released, in a filtered mode, `filt_o` is 0. The event counter and the prescaler both start from zero.
- R2: With `mode_i` = 4'd0, `filt_o` equals `raw_i` at all times, with no clock edge needed.
- R3: Modes 4'd1, 4'd2 and 4'd3 sample on every clock and need 2, 4 and 8 samples. A level change on `raw_i` that holds steady appears on `filt_o` exactly N+2 clock edges later, where 2 edges are the synchronizer.
- R4: In the dead-time modes, mode value and its divisor D and count N are: 4 (D=2,N=6), 5 (2,8), 6 (4,6), 7 (4,8), 8 (8,6), 9 (8,8), 10 (16,5), 11 (16,6), 12 (16,8), 13 (32,5), 14 (32,6), 15 (32,8).
- R5: A sample equal to the current filtered level clears the event counter. A pulse that gives fewer than N samples is rejected, and two short pulses split by one opposite sample do not add up.
- R6: In a dead-time mode, `filt_o` holds its value while `dts_tick_i` stays low, whatever `raw_i` does.
- R7: In a filtered mode, the filtered level changes only in a cycle that has a sampling enable. When it changes, it takes the synchronized input value.
- R8: Rising and falling transitions are filtered the same way, with the same count and latency.
- R9: With `dts_tick_i` held high, a dead-time mode samples once every D clocks. A steady new level therefore appears on `filt_o` after more than 2+(N-1)·D edges and no later than 2+N·D edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | 1 | Unfiltered fault line |
| mode_i | input | 4 | Filter mode: sampling rate and event count |
| dts_tick_i | input | 1 | One-cycle enable per dead-time clock period |
| filt_o | output | 1 | Filtered fault level |

## Verification
Some properties are checked on every cycle:
- In bypass mode the output equals the raw line.
- Kernel modes sample on every cycle.
- A dead-time mode does not sample without a tick.
- The filtered level moves only on a sampling enable, and only to the synchronized value.
- The event counter stays below 8.

Only the directed scenarios can show the following:
- The exact N+2 edge latency of the kernel modes.
- The latency bounds of all twelve divisor and count pairs.
- That split short pulses do not add up.

// File: rtl/fif_pkg.sv
`timescale 1ns/1ps
package fif_pkg;
  localparam int MODE_W       = 4;
  localparam int MAX_DIV_LOG2 = 5;
  localparam int CNT_W        = 4;
  localparam int SYNC_STAGES  = 2;

  typedef struct packed {
    logic             use_dts;
    logic [2:0]       div_log2;
    logic [CNT_W-1:0] n_evt;
  } fif_cfg_t;

  function automatic fif_cfg_t fif_decode(input logic [MODE_W-1:0] m);
    fif_cfg_t c;
    case (m)
      4'd0:    c = '{1'b0, 3'd0, 4'd1};
      4'd1:    c = '{1'b0, 3'd0, 4'd2};
      4'd2:    c = '{1'b0, 3'd0, 4'd4};
      4'd3:    c = '{1'b0, 3'd0, 4'd8};
      4'd4:    c = '{1'b1, 3'd1, 4'd6};
      4'd5:    c = '{1'b1, 3'd1, 4'd8};
      4'd6:    c = '{1'b1, 3'd2, 4'd6};
      4'd7:    c = '{1'b1, 3'd2, 4'd8};
      4'd8:    c = '{1'b1, 3'd3, 4'd6};
      4'd9:    c = '{1'b1, 3'd3, 4'd8};
      4'd10:   c = '{1'b1, 3'd4, 4'd5};
      4'd11:   c = '{1'b1, 3'd4, 4'd6};
      4'd12:   c = '{1'b1, 3'd4, 4'd8};
      4'd13:   c = '{1'b1, 3'd5, 4'd5};
      4'd14:   c = '{1'b1, 3'd5, 4'd6};
      default: c = '{1'b1, 3'd5, 4'd8};
    endcase
    return c;
  endfunction
endpackage

// File: rtl/fif_sync.sv
`timescale 1ns/1ps
module fif_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/fif_prescaler.sv
`timescale 1ns/1ps
module fif_prescaler #(
  parameter int MAX_LOG2 = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       use_dts_i,
  input  logic [2:0] div_log2_i,
  input  logic       tick_i,
  output logic       sample_en_o
);
  localparam int W = MAX_LOG2;

  logic [W-1:0] cnt_q;
  logic [W:0]   lim_w;
  logic [W-1:0] lim;
  logic         wrap;

  assign lim_w = ((W+1)'(1) << div_log2_i) - (W+1)'(1);
  assign lim   = lim_w[W-1:0];
  // >= so a mode switch to a smaller divisor cannot strand the counter
  assign wrap  = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!use_dts_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= wrap ? '0 : cnt_q + W'(1);
  end

  assign sample_en_o = use_dts_i ? (tick_i && wrap) : 1'b1;
endmodule

// File: rtl/fif_evt_cnt.sv
`timescale 1ns/1ps
module fif_evt_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bypass_i,
  input  logic             sample_en_i,
  input  logic             d_i,
  input  logic [CNT_W-1:0] n_evt_i,
  output logic             q_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             lvl_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt = cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (bypass_i) begin
      // track synced input so leaving bypass starts from the current level
      lvl_q <= d_i;
      cnt_q <= '0;
    end else if (sample_en_i) begin
      if (d_i == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_nxt >= n_evt_i) begin
        lvl_q <= d_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_nxt;
      end
    end
  end

  assign q_o   = lvl_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/fault_input_filter.sv
`timescale 1ns/1ps
module fault_input_filter
  import fif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              raw_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              dts_tick_i,
  output logic              filt_o
);
  fif_cfg_t         cfg;
  logic             bypass;
  logic             sync_q;
  logic             sample_en;
  logic             filt_q;
  logic [CNT_W-1:0] evt_cnt;

  assign cfg    = fif_decode(mode_i);
  assign bypass = (mode_i == '0);

  fif_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_i),
    .q_o    (sync_q)
  );

  fif_prescaler #(.MAX_LOG2(MAX_DIV_LOG2)) u_pre (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .use_dts_i   (cfg.use_dts),
    .div_log2_i  (cfg.div_log2),
    .tick_i      (dts_tick_i),
    .sample_en_o (sample_en)
  );

  fif_evt_cnt #(.CNT_W(CNT_W)) u_evt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bypass_i    (bypass),
    .sample_en_i (sample_en),
    .d_i         (sync_q),
    .n_evt_i     (cfg.n_evt),
    .q_o         (filt_q),
    .cnt_o       (evt_cnt)
  );

  assign filt_o = bypass ? raw_i : filt_q;
endmodule

// File: rtl/fif_checker.sv
`timescale 1ns/1ps
module fif_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       raw_i,
  input logic [3:0] mode_i,
  input logic       dts_tick_i,
  input logic       filt_o,
  input logic       sample_en,
  input logic       filt_q,
  input logic       sync_q,
  input logic [3:0] evt_cnt
);
  assert_bypass_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'd0) |-> (filt_o == raw_i));

  assert_kernel_rate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i inside {4'd1, 4'd2, 4'd3}) |-> sample_en);

  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_cnt < 4'd8);

  assert_no_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i >= 4'd4 && !dts_tick_i) |-> !sample_en);

  assert_hold_without_sample_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 4'd0 && !sample_en) |=> $stable(filt_q));

  assert_change_to_sync_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (filt_q == $past(filt_q) || filt_q == $past(sync_q)));
endmodule

bind fault_input_filter fif_checker u_fif_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .raw_i      (raw_i),
  .mode_i     (mode_i),
  .dts_tick_i (dts_tick_i),
  .filt_o     (filt_o),
  .sample_en  (sample_en),
  .filt_q     (filt_q),
  .sync_q     (sync_q),
  .evt_cnt    (evt_cnt)
);

// File: tb/fault_input_filter_tb_top.sv
`timescale 1ns/1ps
module fault_input_filter_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       raw = 1'b0;
  logic [3:0] mode = 4'd1;
  logic       tick = 1'b0;
  logic       filt;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  fault_input_filter dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .raw_i      (raw),
    .mode_i     (mode),
    .dts_tick_i (tick),
    .filt_o     (filt)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: filt_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle(input logic lvl, input int cyc);
    @(negedge clk) raw = lvl;
    repeat (cyc) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    mode = 4'd1; raw = 1'b0; rst_ni = 1'b0;
    #5 chk(filt, 1'b0, "R1 during reset");
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    @(negedge clk) chk(filt, 1'b0, "R1 after release");
  endtask

  task automatic t_bypass();
    @(negedge clk) mode = 4'd0;
    #2 raw = 1'b1; #1 chk(filt, 1'b1, "R2 rise no clock");
    #2 raw = 1'b0; #1 chk(filt, 1'b0, "R2 fall no clock");
    #2 raw = 1'b1; #1 chk(filt, 1'b1, "R2 rise again");
    settle(1'b0, 6);
    chk(filt, 1'b0, "R2 settled low");
  endtask

  // R3 R8: exact N+2 latency both ways
  task automatic t_kernel(input logic [3:0] m, input int n);
    @(negedge clk) mode = m;
    settle(1'b0, 12);
    for (int dir = 0; dir < 2; dir++) begin
      logic newl;
      newl = (dir == 0);
      raw = newl;
      repeat (n + 1) @(posedge clk);
      @(negedge clk) chk(filt, ~newl, $sformatf("R3 R8 mode %0d still old", m));
      @(posedge clk);
      @(negedge clk) chk(filt, newl, $sformatf("R3 R8 mode %0d new level", m));
    end
  endtask

  // R5: short pulses rejected, split pulses do not add up
  task automatic t_glitch();
    logic seen;
    @(negedge clk) mode = 4'd2;
    settle(1'b0, 12);
    seen = 1'b0;
    raw = 1'b1;
    for (int c = 0; c < 3; c++) begin @(posedge clk); @(negedge clk); seen |= filt; end
    raw = 1'b0;
    @(posedge clk); @(negedge clk); seen |= filt;
    raw = 1'b1;
    for (int c = 0; c < 3; c++) begin @(posedge clk); @(negedge clk); seen |= filt; end
    raw = 1'b0;
    for (int c = 0; c < 10; c++) begin @(posedge clk); @(negedge clk); seen |= filt; end
    chk(seen, 1'b0, "R5 split pulses rejected");
    raw = 1'b1;
    for (int c = 0; c < 4; c++) begin @(posedge clk); @(negedge clk); end
    raw = 1'b0;
    for (int c = 0; c < 2; c++) begin @(posedge clk); @(negedge clk); end
    chk(filt, 1'b1, "R5 four-sample pulse accepted");
    settle(1'b0, 10);
    chk(filt, 1'b0, "R5 back low");
  endtask

  // R4 R9: latency window for each divisor/count pair with tick held high
  task automatic t_divided(input logic [3:0] m, input int d, input int n);
    @(negedge clk) mode = m; tick = 1'b1;
    settle(1'b0, n * d + 8);
    raw = 1'b1;
    repeat (2 + (n - 1) * d) @(posedge clk);
    @(negedge clk) chk(filt, 1'b0, $sformatf("R4 R9 mode %0d not before window", m));
    repeat (d) @(posedge clk);
    @(negedge clk) chk(filt, 1'b1, $sformatf("R4 R9 mode %0d by window end", m));
    settle(1'b0, n * d + 8);
    chk(filt, 1'b0, $sformatf("R4 mode %0d falls back", m));
  endtask

  // R6: no tick, no change
  task automatic t_no_tick();
    logic seen;
    @(negedge clk) mode = 4'd5; tick = 1'b1;
    settle(1'b0, 30);
    tick = 1'b0; raw = 1'b1; seen = 1'b0;
    for (int c = 0; c < 100; c++) begin @(posedge clk); @(negedge clk); seen |= filt; end
    chk(seen, 1'b0, "R6 holds without tick");
    tick = 1'b1;
    repeat (30) @(posedge clk);
    @(negedge clk) chk(filt, 1'b1, "R6 follows once ticks resume");
    settle(1'b0, 30);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_bypass();
    t_kernel(4'd1, 2);
    t_kernel(4'd2, 4);
    t_kernel(4'd3, 8);
    t_glitch();
    t_divided(4'd4, 2, 6);
    t_divided(4'd5, 2, 8);
    t_divided(4'd6, 4, 6);
    t_divided(4'd7, 4, 8);
    t_divided(4'd8, 8, 6);
    t_divided(4'd9, 8, 8);
    t_divided(4'd10, 16, 5);
    t_divided(4'd11, 16, 6);
    t_divided(4'd12, 16, 8);
    t_divided(4'd13, 32, 5);
    t_divided(4'd14, 32, 6);
    t_divided(4'd15, 32, 8);
    t_no_tick();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule